// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO

A single-clock first-in first-out buffer with parameters for word width and storage depth. A third parameter selects how reads behave. In standard mode a read request is sampled at a clock edge, and the word it fetches appears on `dout` just after that same edge. In look-ahead mode the oldest word is already on `dout` whenever `empty` is low. Asserting `rd_en` takes that word, and the next word is presented straight away.

The look-ahead variant puts a two-word staging path between the storage array and the output. That path costs two cycles of extra latency before `empty` drops after the first write, and it raises total capacity to depth plus two words. The external reset is asserted asynchronously, and its release is retimed through a chain of three flops before it frees the logic. The fill count is delayed by two clocks relative to the words actually held.

Top module: `dual_mode_fifo`

## Requirements
- R1: While reset is in effect, `fill_count` is 0, `empty` is 1, `full` is 0 and `dout` is 0, whatever the FIFO held before.
- R2: After `rst_i` falls, the three clock edges that follow still treat the FIFO as in reset, so writes presented on those edges are dropped. A write on the fourth edge is accepted.
- R3: In standard mode (MODE = 0), a read accepted at a clock edge places the oldest stored word on `dout` right after that edge. `dout` keeps its value until the next accepted read.
- R4: In look-ahead mode (MODE = 1), whenever `empty` is low, `dout` already shows the oldest word. A read accepted at an edge replaces it with the next word right after that edge, with no added cycle.
- R5: When a write is accepted at edge E into an empty FIFO, `empty` goes low right after E in standard mode. In look-ahead mode it goes low right after edge E+2.
- R6: `full` goes high once DEPTH words are held in standard mode, or DEPTH+2 words in look-ahead mode when filled by back-to-back writes.
- R7: A read accepted while `full` is high makes `full` low right after that edge.
- R8: A read that takes the last held word makes `empty` high right after that edge.
- R9: The value of `fill_count` right after edge E+2 equals the number of words held right after edge E. In look-ahead mode this number includes the words in the staging path.
- R10: A write while `full` is high and a read while `empty` is high are both ignored. The count, the stored words and their order are unchanged.
- R11: Under any mix of reads and writes, words leave in the order they were accepted, with no word lost or repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all logic |
| rst_i | input | 1 | Active-high reset; asserted asynchronously, release retimed internally |
| din | input | DATA_W | Word to store |
| wr_en | input | 1 | Write request, accepted when `full` is low |
| rd_en | input | 1 | Read request, accepted when `empty` is low |
| dout | output | DATA_W | Read word (registered in standard mode, head word in look-ahead mode) |
| full | output | 1 | No further write can be accepted |
| empty | output | 1 | No word is available to read |
| fill_count | output | $clog2(DEPTH)+1 | Words held, delayed by two clocks |

## Verification
The bench runs a standard instance and a look-ahead instance side by side on the same stimulus. It aims at the cycle on which each flag moves. Some likely faults are an `empty` that drops too early in look-ahead mode (a staging stage left out), a `full` that rises at DEPTH in look-ahead mode (stage words not counted), or a count with one register too few or too many. It also drives writes during the three retimed reset edges, and it pushes past full and reads past empty. A design that wraps a pointer there would show up as a repeated or missing word in the random phases, or as a count that creeps away from DEPTH or zero. A mid-run reset with data in flight checks that a reset which leaves stale contents or a nonzero `dout` is caught.

// File: rtl/dmfifo_pkg.sv
package dmfifo_pkg;
   typedef enum logic {
      RD_STANDARD = 1'b0,
      RD_AHEAD    = 1'b1
   } rd_mode_e;
endpackage

// File: rtl/dmfifo_rst_sync.sv
// Reset retimer: asynchronous assertion, release after STAGES clock edges.
module dmfifo_rst_sync #(
   parameter int STAGES = 3
) (
   input  logic clk,
   input  logic arst,
   output logic srst
);
   logic [STAGES-1:0] chain;

   initial begin
      assert (STAGES >= 2) else $error("dmfifo_rst_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or posedge arst) begin
      if (arst) chain <= '1;
      else      chain <= {chain[STAGES-2:0], 1'b0};
   end

   assign srst = chain[STAGES-1];

   // R2: once released, the retimed reset stays low until the source is asserted again
   p_release_holds_r2: assert property (@(posedge clk) disable iff (arst)
      !srst |=> !srst);
endmodule

// File: rtl/dmfifo_store.sv
// Storage array with pointers, occupancy and a registered read port.
module dmfifo_store #(
   parameter int W     = 32,
   parameter int DEPTH = 2048,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          srst,
   input  logic          wr_en,
   input  logic [W-1:0]  wr_data,
   input  logic          rd_en,
   output logic [W-1:0]  rd_data,
   output logic          full,
   output logic          empty,
   output logic [CW-1:0] fill
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          wr_ok, rd_ok;

   assign full  = (fill == CW'(DEPTH));
   assign empty = (fill == '0);
   assign wr_ok = wr_en & ~full;
   assign rd_ok = rd_en & ~empty;

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk or posedge srst) begin
      if (srst) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         fill    <= '0;
         rd_data <= '0;
      end else begin
         if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
         if (rd_ok) begin
            rd_ptr  <= rd_ptr + 1'b1;
            rd_data <= mem[rd_ptr];
         end
         unique case ({wr_ok, rd_ok})
            2'b10:   fill <= fill + 1'b1;
            2'b01:   fill <= fill - 1'b1;
            default: fill <= fill;
         endcase
      end
   end

   p_no_overflow_r10: assert property (@(posedge clk) disable iff (srst)
      full && wr_en && !rd_en |=> fill == CW'(DEPTH));
   p_no_underflow_r10: assert property (@(posedge clk) disable iff (srst)
      empty && rd_en && !wr_en |=> empty && $stable(rd_data));
   p_full_drop_r7: assert property (@(posedge clk) disable iff (srst)
      full && rd_en |=> !full);
   p_last_read_r8: assert property (@(posedge clk) disable iff (srst)
      fill == CW'(1) && rd_en && !wr_en |=> empty);
   p_first_write_r5: assert property (@(posedge clk) disable iff (srst)
      empty && wr_en |=> !empty);
endmodule

// File: rtl/dmfifo_ahead.sv
// Two-word look-ahead path: one stage word held in the store's read register,
// one head word on the output register.
module dmfifo_ahead #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         srst,
   input  logic         src_empty,
   input  logic [W-1:0] src_data,
   output logic         src_rd,
   input  logic         rd_en,
   output logic [W-1:0] dout,
   output logic         out_valid,
   output logic         stage_valid
);
   logic pop, load_out, stage_move;

   assign pop        = rd_en & out_valid;
   assign load_out   = ~out_valid | pop;
   assign stage_move = stage_valid & load_out;
   assign src_rd     = ~src_empty & (~stage_valid | stage_move);

   always_ff @(posedge clk or posedge srst) begin
      if (srst) begin
         out_valid   <= 1'b0;
         stage_valid <= 1'b0;
         dout        <= '0;
      end else begin
         if (load_out) begin
            out_valid <= stage_valid;
            if (stage_valid) dout <= src_data;
         end
         if (src_rd)          stage_valid <= 1'b1;
         else if (stage_move) stage_valid <= 1'b0;
      end
   end

   // R4: an unread head word stays put
   p_head_hold_r4: assert property (@(posedge clk) disable iff (srst)
      out_valid && !rd_en |=> out_valid && $stable(dout));
   // R4: a staged word reaches an idle output on the next edge
   p_stage_forward_r4: assert property (@(posedge clk) disable iff (srst)
      stage_valid && !out_valid |=> out_valid);
endmodule

// File: rtl/dmfifo_lag.sv
// Fixed-depth register delay used for the fill count.
module dmfifo_lag #(
   parameter int W      = 12,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         srst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] pipe [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
         always_ff @(posedge clk or posedge srst) begin
            if (srst) pipe[i] <= '0;
            else      pipe[i] <= d;
         end
      end else begin : g_tail
         always_ff @(posedge clk or posedge srst) begin
            if (srst) pipe[i] <= '0;
            else      pipe[i] <= pipe[i-1];
         end
      end
   end

   assign q = pipe[STAGES-1];

   if (STAGES == 2) begin : g_chk
      p_count_lag_r9: assert property (@(posedge clk) disable iff (srst)
         q == $past(d, 2));
   end
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo
   import dmfifo_pkg::*;
#(
   parameter int       DATA_W      = 32,
   parameter int       DEPTH       = 2048,
   parameter rd_mode_e MODE        = RD_STANDARD,
   parameter int       SYNC_STAGES = 3,
   localparam int      CNT_W       = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_i,
   input  logic [DATA_W-1:0] din,
   input  logic              wr_en,
   input  logic              rd_en,
   output logic [DATA_W-1:0] dout,
   output logic              full,
   output logic              empty,
   output logic [CNT_W-1:0]  fill_count
);
   initial begin
      assert (DEPTH >= 4 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("dual_mode_fifo: DEPTH must be a power of two, at least 4");
      assert (DATA_W >= 1) else $error("dual_mode_fifo: DATA_W must be positive");
   end

   logic              srst;
   logic              core_rd, core_full, core_empty;
   logic [DATA_W-1:0] core_q;
   logic [CNT_W-1:0]  core_fill, occ;

   dmfifo_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
      .clk  (clk),
      .arst (rst_i),
      .srst (srst)
   );

   dmfifo_store #(.W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .srst    (srst),
      .wr_en   (wr_en),
      .wr_data (din),
      .rd_en   (core_rd),
      .rd_data (core_q),
      .full    (core_full),
      .empty   (core_empty),
      .fill    (core_fill)
   );

   if (MODE == RD_AHEAD) begin : g_ahead
      logic out_v, stage_v;
      dmfifo_ahead #(.W(DATA_W)) u_ahead (
         .clk         (clk),
         .srst        (srst),
         .src_empty   (core_empty),
         .src_data    (core_q),
         .src_rd      (core_rd),
         .rd_en       (rd_en),
         .dout        (dout),
         .out_valid   (out_v),
         .stage_valid (stage_v)
      );
      assign empty = ~out_v;
      assign occ   = core_fill + CNT_W'(out_v) + CNT_W'(stage_v);
   end else begin : g_std
      assign core_rd = rd_en;
      assign dout    = core_q;
      assign empty   = core_empty;
      assign occ     = core_fill;
   end

   assign full = core_full;

   dmfifo_lag #(.W(CNT_W), .STAGES(2)) u_lag (
      .clk  (clk),
      .srst (srst),
      .d    (occ),
      .q    (fill_count)
   );

   p_flags_excl_r6: assert property (@(posedge clk) disable iff (srst)
      !(full && empty));
   p_count_max_r9: assert property (@(posedge clk) disable iff (srst)
      fill_count <= CNT_W'(DEPTH + 2));
   p_reset_out_r1: assert property (@(posedge clk)
      srst |-> empty && !full && fill_count == '0 && dout == '0);
endmodule

// File: tb/sim_dual_mode_fifo.sv
module sim_dual_mode_fifo;
   import dmfifo_pkg::*;

   localparam int W  = 32;
   localparam int D  = 16;
   localparam int CW = $clog2(D) + 1;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst = 1'b0;
   logic [W-1:0]  din = '0;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [W-1:0]  dout0, dout1;
   logic          full0, full1, empty0, empty1;
   logic [CW-1:0] fill0, fill1;

   dual_mode_fifo #(.DATA_W(W), .DEPTH(D), .MODE(RD_STANDARD)) u0 (
      .clk(clk), .rst_i(rst), .din(din), .wr_en(wr_en), .rd_en(rd_en),
      .dout(dout0), .full(full0), .empty(empty0), .fill_count(fill0));

   dual_mode_fifo #(.DATA_W(W), .DEPTH(D), .MODE(RD_AHEAD)) u1 (
      .clk(clk), .rst_i(rst), .din(din), .wr_en(wr_en), .rd_en(rd_en),
      .dout(dout1), .full(full1), .empty(empty1), .fill_count(fill1));

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   // behavioural models
   logic [2:0]   mp = 3'b111;
   logic [W-1:0] sq[$];
   logic [W-1:0] s_dout = '0;
   int           s_c1 = 0, s_c2 = 0;
   logic [W-1:0] fq[$];
   bit           fs_v = 0, fo_v = 0;
   logic [W-1:0] fs_d = '0, fo_d = '0;
   int           f_c1 = 0, f_c2 = 0;

   function automatic int f_occ();
      return fq.size() + int'(fs_v) + int'(fo_v);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic model_edge();
      bit pre, pop, load, mv, iss, wok;
      int s_occ, f_oc;
      pre   = mp[2];
      mp    = rst ? 3'b111 : {mp[1:0], 1'b0};
      s_occ = sq.size();
      f_oc  = f_occ();
      if (!pre) begin
         s_c2 = s_c1; s_c1 = s_occ;
         if (rd_en && s_occ > 0) s_dout = sq.pop_front();
         if (wr_en && s_occ < D) sq.push_back(din);
         f_c2 = f_c1; f_c1 = f_oc;
         wok  = wr_en && fq.size() < D;
         pop  = rd_en && fo_v;
         load = !fo_v || pop;
         mv   = fs_v && load;
         iss  = fq.size() > 0 && (!fs_v || mv);
         if (load) begin
            if (fs_v) fo_d = fs_d;
            fo_v = fs_v;
         end
         if (iss) begin
            fs_d = fq.pop_front();
            fs_v = 1'b1;
         end else if (mv) fs_v = 1'b0;
         if (wok) fq.push_back(din);
      end
      if (mp[2]) begin
         sq.delete(); fq.delete();
         s_dout = '0; s_c1 = 0; s_c2 = 0;
         fs_v = 0; fo_v = 0; fs_d = '0; fo_d = '0; f_c1 = 0; f_c2 = 0;
      end
   endtask

   task automatic compare(input string ts, input string tf);
      chk(dout0 == s_dout, ts, "std dout", dout0, s_dout);
      chk(empty0 == (sq.size() == 0), "R5", "std empty", empty0, sq.size() == 0);
      chk(full0 == (sq.size() == D), "R6", "std full", full0, sq.size() == D);
      chk(int'(fill0) == s_c2, "R9", "std count", fill0, s_c2);
      if (fo_v) chk(dout1 == fo_d, tf, "ahead dout", dout1, fo_d);
      chk(empty1 == !fo_v, "R5", "ahead empty", empty1, !fo_v);
      chk(full1 == (fq.size() == D), "R6", "ahead full", full1, fq.size() == D);
      chk(int'(fill1) == f_c2, "R9", "ahead count", fill1, f_c2);
   endtask

   task automatic step(input bit w, input bit r, input bit rs,
                       input string ts = "R3", input string tf = "R4");
      wr_en = w; rd_en = r; rst = rs; din = $urandom;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare(ts, tf);
   endtask

   task automatic reset_state_checks();
      chk(dout0 == '0, "R1", "std dout", dout0, 0);
      chk(empty0 == 1'b1, "R1", "std empty", empty0, 1);
      chk(full0 == 1'b0, "R1", "std full", full0, 0);
      chk(fill0 == '0, "R1", "std count", fill0, 0);
      chk(dout1 == '0, "R1", "ahead dout", dout1, 0);
      chk(empty1 == 1'b1, "R1", "ahead empty", empty1, 1);
      chk(full1 == 1'b0, "R1", "ahead full", full1, 0);
      chk(fill1 == '0, "R1", "ahead count", fill1, 0);
   endtask

   task automatic random_phase(input int pw, input int pr, input int n);
      for (int k = 0; k < n; k++)
         step($urandom_range(99) < pw, $urandom_range(99) < pr, 1'b0, "R11", "R11");
   endtask

   initial begin
      logic [W-1:0] a, b;
      void'($urandom(32'd20240611));
      #1 rst = 1'b1;
      @(negedge clk);
      repeat (3) step(0, 0, 1);
      reset_state_checks();

      // R2: writes during the retimed release are dropped
      repeat (3) step(1, 0, 0);
      repeat (3) step(0, 0, 0);
      chk(empty0 == 1'b1, "R2", "std empty", empty0, 1);
      chk(fill0 == '0, "R2", "std count", fill0, 0);
      chk(empty1 == 1'b1, "R2", "ahead empty", empty1, 1);
      chk(fill1 == '0, "R2", "ahead count", fill1, 0);

      // R5 / R4: first write latency
      step(1, 0, 0); a = din;
      chk(empty0 == 1'b0, "R5", "std empty after write", empty0, 0);
      chk(empty1 == 1'b1, "R5", "ahead empty E", empty1, 1);
      step(0, 0, 0);
      chk(empty1 == 1'b1, "R5", "ahead empty E+1", empty1, 1);
      step(0, 0, 0);
      chk(empty1 == 1'b0, "R5", "ahead empty E+2", empty1, 0);
      chk(dout1 == a, "R4", "ahead head word", dout1, a);

      // R3 / R8: single read
      step(0, 1, 0);
      chk(dout0 == a, "R3", "std read word", dout0, a);
      chk(empty0 == 1'b1, "R8", "std empty after last", empty0, 1);
      chk(empty1 == 1'b1, "R8", "ahead empty after last", empty1, 1);

      // R6: fill thresholds
      for (int i = 0; i < D + 4; i++) begin
         step(1, 0, 0);
         if (i == D - 2) chk(full0 == 1'b0, "R6", "std full early", full0, 0);
         if (i == D - 1) chk(full0 == 1'b1, "R6", "std full at DEPTH", full0, 1);
         if (i == D)     chk(full1 == 1'b0, "R6", "ahead full early", full1, 0);
         if (i == D + 1) chk(full1 == 1'b1, "R6", "ahead full at DEPTH+2", full1, 1);
      end
      repeat (2) step(0, 0, 0);
      chk(int'(fill0) == D, "R10", "std count after overfill", fill0, D);
      chk(int'(fill1) == D + 2, "R10", "ahead count after overfill", fill1, D + 2);

      // R7
      step(0, 1, 0);
      chk(full0 == 1'b0, "R7", "std full after read", full0, 0);
      chk(full1 == 1'b0, "R7", "ahead full after read", full1, 0);

      // drain and over-read
      repeat (D + 6) step(0, 1, 0);
      chk(empty0 == 1'b1, "R8", "std drained", empty0, 1);
      chk(empty1 == 1'b1, "R8", "ahead drained", empty1, 1);
      repeat (2) step(0, 0, 0);
      chk(fill0 == '0, "R10", "std count after over-read", fill0, 0);
      chk(fill1 == '0, "R10", "ahead count after over-read", fill1, 0);
      step(1, 0, 0); b = din;
      repeat (3) step(0, 0, 0);
      chk(dout1 == b, "R10", "ahead word after over-read", dout1, b);
      step(0, 1, 0);
      chk(dout0 == b, "R10", "std word after over-read", dout0, b);

      // R11: random traffic
      random_phase(70, 30, 400);
      random_phase(50, 50, 600);
      random_phase(30, 70, 400);
      random_phase(90, 90, 400);

      // R1: reset with data in flight
      random_phase(80, 10, 60);
      step(0, 0, 1);
      step(1, 1, 1);
      reset_state_checks();
      repeat (3) step(0, 0, 0);
      random_phase(60, 40, 600);
      random_phase(20, 20, 300);
      random_phase(95, 5, 100);
      random_phase(5, 95, 100);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R11 watchdog expired: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule